// File: doc/BRIEF.md
# Pin Interrupt Mode Controller

This block turns eight asynchronous pin inputs into eight interrupt request lines. Each channel can be set to edge sensing or level sensing. Software sets this up through a small 32-bit register bus that has separate write and read strobes, a word address, and write and read data. Every pin passes through a synchronizer before it reaches an edge detector. In edge mode, an enabled edge latches a sticky status bit, and that bit holds the request until software writes a one to it. In level mode, the request follows the synchronized pin while the channel is enabled and the pin matches the chosen active level.

Two per-channel registers change meaning with the mode. The enable register gates rising edges in edge mode and gates the level request in level mode. Software can update it three ways: a direct write, a set alias where ones set bits, and a clear alias where ones clear bits. The second register enables falling edges in edge mode and selects the active level in level mode.

Register map (word address): 0 = mode (1 = level), 1 = enable, 2 = enable set alias, 3 = enable clear alias, 4 = falling/polarity, 5 = edge status (write one to clear). Channel n uses bit n. Read data is registered and appears on the clock edge that samples the read strobe.

Top module: `pint_ctrl`

## Requirements
- R1: After reset, every register reads zero and all request lines are low.
- R2: The mode, enable and falling/polarity registers keep bits 7:0. Bits 31:8 are not stored, read as zero, and ignore writes.
- R3: Writing to address 2 sets each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R4: Writing to address 3 clears each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. A direct write to address 1 replaces the enable bits.
- R5: Reading address 2 or address 3 returns zero.
- R6: In edge mode (mode bit 0) with the enable bit 1, a rising pin sets the channel's status bit (address 5). The request goes high within four clock cycles.
- R7: In edge mode, a falling pin sets status and raises the request only if the falling/polarity bit is 1. An edge whose enable is 0 changes neither status nor the request.
- R8: An edge status bit stays set until a 1 is written to it at address 5. Writing 0 leaves it set. Clearing it drops the request one cycle later.
- R9: In level mode (mode bit 1), the request is high exactly while the enable bit is 1 and the synchronized pin equals the active level (polarity 1 = high, 0 = low). Level mode never sets status.
- R10: If an enabled edge is detected in the same cycle as a write of 1 to its status bit, the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous pin inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 8 | Registered interrupt requests |

## Verification
The bench targets the alias writes whose zero bits must leave the enable register alone. A design that treated an alias as a plain store would wipe the other enables. It checks that a channel enabled only for falling edges ignores a rising edge, which catches a design that swaps or merges the two enables. A status clear is timed to land on the same cycle as a fresh edge: a design where the clear wins would lose that interrupt. Level channels are checked at both polarities and with enable off, which catches an inverted level compare or a level request that latches status.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int OFS_MODE   = 0;
  localparam int OFS_EN     = 1;
  localparam int OFS_EN_SET = 2;
  localparam int OFS_EN_CLR = 3;
  localparam int OFS_POL    = 4;
  localparam int OFS_STAT   = 5;
endpackage

// File: rtl/pint_sync_edge.sv
module pint_sync_edge #(
  parameter int NCH    = 8,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] lvl_o,
  output logic [NCH-1:0] rise_o,
  output logic [NCH-1:0] fall_o
);
  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
        prev_q  <= chain_q[LAST];
      end
    end

    assign lvl_o[g]  = chain_q[LAST];
    assign rise_o[g] = chain_q[LAST] & ~prev_q;
    assign fall_o[g] = ~chain_q[LAST] & prev_q;
  end
endmodule

// File: rtl/pint_status.sv
module pint_status #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] stat_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           stat_o[g] <= 1'b0;
      else if (set_i[g]) stat_o[g] <= 1'b1;
      else if (clr_i[g]) stat_o[g] <= 1'b0;
    end

    // R10: a new edge beats a concurrent clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> stat_o[g]);
    // R8: sticky until cleared
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      (stat_o[g] && !clr_i[g]) |=> stat_o[g]);
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !set_i[g]) |=> !stat_o[g]);
  end
endmodule

// File: rtl/pint_regs.sv
module pint_regs
  import pint_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 32,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] stat_i,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] mode_o,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] pol_o,
  output logic [NCH-1:0] stat_clr_o
);
  logic [NCH-1:0] wbits;
  logic [NCH-1:0] en_set, en_clr;
  logic [DW-1:0]  rd_mux;
  logic           hit_mode, hit_en, hit_set, hit_clr, hit_pol, hit_stat;
  logic           unused_hi;

  assign wbits     = wdata[NCH-1:0];
  assign unused_hi = ^wdata;

  assign hit_mode = wr_en && (addr == AW'(OFS_MODE));
  assign hit_en   = wr_en && (addr == AW'(OFS_EN));
  assign hit_set  = wr_en && (addr == AW'(OFS_EN_SET));
  assign hit_clr  = wr_en && (addr == AW'(OFS_EN_CLR));
  assign hit_pol  = wr_en && (addr == AW'(OFS_POL));
  assign hit_stat = wr_en && (addr == AW'(OFS_STAT));

  assign en_set     = hit_set  ? wbits : '0;
  assign en_clr     = hit_clr  ? wbits : '0;
  assign stat_clr_o = hit_stat ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= '0;
      en_o   <= '0;
      pol_o  <= '0;
    end else begin
      if (hit_mode) mode_o <= wbits;
      if (hit_pol)  pol_o  <= wbits;
      if (hit_en)   en_o   <= wbits;
      else          en_o   <= (en_o | en_set) & ~en_clr;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      AW'(OFS_MODE): rd_mux = DW'(mode_o);
      AW'(OFS_EN):   rd_mux = DW'(en_o);
      AW'(OFS_POL):  rd_mux = DW'(pol_o);
      AW'(OFS_STAT): rd_mux = DW'(stat_i);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  a_r3_set_alias: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_EN_SET)) |=> ((en_o & $past(wbits)) == $past(wbits)));
  a_r4_clear_alias: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_EN_CLR)) |=> ((en_o & $past(wbits)) == '0));
  a_r5_alias_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == AW'(OFS_EN_SET) || addr == AW'(OFS_EN_CLR))) |=> (rdata == '0));
endmodule

// File: rtl/pint_ctrl.sv
module pint_ctrl #(
  parameter int NCH         = 8,
  parameter int DW          = 32,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_i,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0] lvl, rise, fall;
  logic [NCH-1:0] mode, en, pol, stat, stat_clr;
  logic [NCH-1:0] edge_set, lvl_req, irq_d;

  pint_sync_edge #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  pint_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .stat_i(stat), .rdata(rdata), .mode_o(mode),
    .en_o(en), .pol_o(pol), .stat_clr_o(stat_clr)
  );

  assign edge_set = ~mode & ((rise & en) | (fall & pol));
  assign lvl_req  = mode & en & ~(lvl ^ pol);
  assign irq_d    = (~mode & stat) | lvl_req;

  pint_status #(.NCH(NCH)) u_stat (
    .clk(clk), .rst(rst), .set_i(edge_set), .clr_i(stat_clr), .stat_o(stat)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= irq_d;
  end

  // R9: status never rises on a level-mode channel
  a_r9_level_no_status: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & ~$past(stat) & $past(mode)) == '0));
  // R1: requests low in the first cycle out of reset
  a_r1_irq_reset: assert property (@(posedge clk)
    $past(rst) |-> (irq_o == '0));
endmodule

// File: tb/pint_ctrl_bench.sv
`timescale 1ns/1ps
module pint_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    bit          is_rd;
    logic [31:0] val;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  pint_ctrl u_pint_ctrl (
    .clk(clk), .rst(rst), .pin_i(pin), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq)
  );

  // monitor: compare queued expectations against outputs
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      act = it.is_rd ? rdata : {24'h0, irq};
      total++;
      if (act !== it.val) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.val);
      end
    end
  end

  task automatic push(input bit r, input logic [31:0] v, input string t);
    item_t it;
    it.is_rd = r; it.val = v; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic exp_rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = 4'(a);
    @(posedge clk); #1; push(1'b1, e, t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic exp_irq(input logic [7:0] e, input string t);
    @(posedge clk); #1; push(1'b0, {24'h0, e}, t);
  endtask

  task automatic set_pin(input int ch, input logic v);
    @(negedge clk); pin[ch] = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1
    exp_irq(8'h00, "R1 irq after reset");
    for (int a = 0; a < 6; a++) exp_rd(a, 32'h0, "R1 register reset value");
    // R2
    bus_wr(0, 32'hFFFF_FFA5); exp_rd(0, 32'hA5, "R2 mode upper bits");
    bus_wr(4, 32'h1234_5678); exp_rd(4, 32'h78, "R2 polarity upper bits");
    bus_wr(1, 32'hFFFF_FF00); exp_rd(1, 32'h00, "R2 enable upper bits");
    bus_wr(0, 32'h0); bus_wr(4, 32'h0);
    // R3 / R5
    bus_wr(2, 32'h05); exp_rd(1, 32'h05, "R3 set alias");
    bus_wr(2, 32'h30); exp_rd(1, 32'h35, "R3 zeros keep enables");
    exp_rd(2, 32'h0, "R5 set alias reads zero");
    exp_rd(3, 32'h0, "R5 clear alias reads zero");
    // R4
    bus_wr(3, 32'h04); exp_rd(1, 32'h31, "R4 clear alias");
    bus_wr(3, 32'h00); exp_rd(1, 32'h31, "R4 zeros keep enables");
    bus_wr(1, 32'h01); exp_rd(1, 32'h01, "R4 direct write");
    // R6
    set_pin(0, 1'b1); exp_irq(8'h01, "R6 rising edge irq");
    exp_rd(5, 32'h01, "R6 rising edge status");
    // R8
    bus_wr(5, 32'hFFFF_FF00); exp_irq(8'h01, "R8 zero write keeps status");
    bus_wr(5, 32'h01); exp_irq(8'h00, "R8 w1c drops irq");
    exp_rd(5, 32'h0, "R8 status cleared");
    // R7
    bus_wr(4, 32'h02);
    set_pin(1, 1'b1); exp_irq(8'h00, "R7 rise ignored on fall-only channel");
    set_pin(1, 1'b0); exp_irq(8'h02, "R7 falling edge irq");
    exp_rd(5, 32'h02, "R7 falling edge status");
    bus_wr(5, 32'h02); exp_irq(8'h00, "R7 cleared");
    set_pin(0, 1'b0); exp_irq(8'h00, "R7 disabled fall ignored");
    exp_rd(5, 32'h0, "R7 no status for disabled edge");
    // R10
    set_pin(0, 1'b1); exp_irq(8'h01, "R10 setup edge");
    set_pin(0, 1'b0);
    @(negedge clk); pin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 4'd5; wdata = 32'h01;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    exp_rd(5, 32'h01, "R10 edge beats concurrent clear");
    exp_irq(8'h01, "R10 irq held");
    bus_wr(5, 32'h01); exp_irq(8'h00, "R10 later clear");
    // R9
    bus_wr(0, 32'h30); bus_wr(4, 32'h12); bus_wr(2, 32'h30);
    exp_irq(8'h20, "R9 active-low level with pin low");
    set_pin(4, 1'b1); exp_irq(8'h30, "R9 active-high level");
    set_pin(5, 1'b1); exp_irq(8'h10, "R9 active-low released");
    set_pin(4, 1'b0); exp_irq(8'h00, "R9 active-high released");
    exp_rd(5, 32'h0, "R9 level sets no status");
    bus_wr(3, 32'h20);
    set_pin(5, 1'b0); exp_irq(8'h00, "R9 disabled level channel");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule